// File: doc/BRIEF.md
# Pixel FIFO Register Readout Port

This block sits between the display FIFO of a compositor and the rest of the chip. It lets a bus master or DMA engine collect composed pixels by polling a single memory-mapped data register, as an alternative to the ordinary streaming output. Pixels arrive from upstream over a valid/ready handshake and wait in a small internal queue.

A control register selects the mode. When register output is off and the block is enabled, pixels flow out of a streaming port. When register output is on, each read of the data register shows the oldest pixel together with valid, empty and end-of-line flags. The read removes the pixel only if it was valid. A packed mode returns two 16-bit pixels per read instead and has no status bits. Writes to the data register request a frame start or a line start. The block tracks column and line positions against the programmed frame size. A one-shot mode delivers exactly one frame per frame start.

Top module: `pix_reg_readout`

## Requirements
- R1: The control register (written whole through `ctrlWe`) decodes enable at bit 31, clear at bit 30, one-shot at bit 29, packing at bit 27, register output at bit 26, frame width in bits 23:12 and frame height in bits 11:0. Bits 28, 25 and 24 are ignored. After reset every field is zero, `dataRdata` reads 0x0200_0000 (only the empty flag), `strmValid` is low and `inPixReady` is high.
- R2: While the clear bit is set, `inPixReady` is low, the internal queue is emptied, the column and line counts return to zero, end-of-line is cleared and frame delivery stops.
- R3: In unpacked register mode `dataRdata` holds the oldest queued pixel in bits 23:0 when valid, valid at bit 24, queue-empty at bit 25 (no pixel held), end-of-line at bit 26, and zero in bits 31:27.
- R4: A read while valid is low removes nothing and shows zero in bits 23:0. Valid is high only when register mode is enabled, a frame is running, end-of-line is clear and enough pixels are queued (one, or two when packed).
- R5: Reading the last column of a line (column count reaching the width) sets end-of-line. End-of-line then holds and blocks delivery until a line-start or frame-start write.
- R6: A data-register write with bit 31 set (frame start) places the position at line 0, column 0, clears end-of-line and starts delivery. Before the first frame start no read is valid.
- R7: In packed mode a valid read returns two pixels in 5-6-5 form (red 15:11, green 10:5, blue 4:0), the older pixel in bits 15:0 and the newer in bits 31:16. The read removes both and advances the column by two. A read that is not valid returns all zeros.
- R8: In one-shot mode, delivery stops once the last pixel of the last line is read, and only a new frame start resumes it. Without one-shot, a line-start write after the last line continues at line 0.
- R9: With enable set and register output clear, queued pixels leave through `strmData` in arrival order under `strmValid`/`strmReady`, and data-register reads are never valid.
- R10: A data-register write in enabled register mode raises `vstartReq` (bit 31) or else `hstartReq` (bit 30) for one cycle, on the clock edge that takes the write.
- R11: A pixel is taken on each cycle with `inPixValid` and `inPixReady` both high. `inPixReady` is high whenever the queue has room and clear is off. No pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inPixValid | input | 1 | Upstream pixel valid |
| inPixData | input | 24 | Upstream RGB pixel, red in 23:16 |
| inPixReady | output | 1 | Block can take a pixel |
| strmValid | output | 1 | Streaming output valid |
| strmData | output | 24 | Streaming output pixel |
| strmReady | input | 1 | Streaming sink ready |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 32 | Control register write value |
| dataRe | input | 1 | Data register read strobe |
| dataRdata | output | 32 | Data register read value, valid in the strobe cycle |
| dataWe | input | 1 | Data register write strobe |
| dataWdata | input | 32 | Data register write value (start requests) |
| vstartReq | output | 1 | Frame start request pulse |
| hstartReq | output | 1 | Line start request pulse |

## Verification
Unpacked reads run through a two-line frame in which the queue sometimes runs dry before the line ends and sometimes holds a spare pixel after it. This separates the empty flag from the end-of-line flag and shows that an invalid read consumes nothing. A one-shot frame followed by line-start and frame-start writes separates one-shot stopping from continuous wrap-around. Packed reads made with one pixel queued, then with two, show the two-pixel threshold and the two-per-read column step. A streaming pass with the sink first stalled and then open checks ordering, and that register reads stay inert in that mode.

// File: rtl/prr_pkg.sv
package prr_pkg;
  localparam int PIX_W = 24;
  localparam int DIM_W = 12;

  // control register bit positions
  localparam int C_EN      = 31;
  localparam int C_CLR     = 30;
  localparam int C_ONESHOT = 29;
  localparam int C_PACK    = 27;
  localparam int C_REGOUT  = 26;

  // data register write request bits
  localparam int W_FRAME = 31;
  localparam int W_LINE  = 30;

  // strobes and view from control to datapath
  typedef struct packed {
    logic       flush;
    logic [1:0] popCnt;
    logic       packSel;
    logic       rdValid;
    logic       eolFlag;
    logic       streamOn;
  } dpCmd_t;

  function automatic logic [15:0] pack565(input logic [PIX_W-1:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction
endpackage

// File: rtl/prr_datapath.sv
module prr_datapath import prr_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             inPixValid,
  input  logic [PIX_W-1:0] inPixData,
  output logic             inPixReady,
  output logic             strmValid,
  output logic [PIX_W-1:0] strmData,
  input  logic             strmReady,
  output logic [31:0]      rdData,
  output logic [CNT_W-1:0] fillCount
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             push, strmPop;
  logic [1:0]       popTotal;
  logic [PIX_W-1:0] headPix, nextPix;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign inPixReady = !cmd.flush && (count < CNT_W'(DEPTH));
  assign push       = inPixValid && inPixReady;
  assign strmValid  = cmd.streamOn && !cmd.flush && (count != '0);
  assign strmPop    = strmValid && strmReady;
  assign popTotal   = cmd.popCnt + {1'b0, strmPop};
  assign headPix    = mem[rdPtr];
  assign nextPix    = mem[bump(rdPtr)];
  assign strmData   = headPix;
  assign fillCount  = count;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inPixData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      case (popTotal)
        2'd1:    rdPtr <= bump(rdPtr);
        2'd2:    rdPtr <= bump(bump(rdPtr));
        default: rdPtr <= rdPtr;
      endcase
      count <= count + CNT_W'(push) - CNT_W'(popTotal);
    end
  end

  always_comb begin
    if (cmd.packSel) begin
      rdData = cmd.rdValid ? {pack565(nextPix), pack565(headPix)} : 32'h0;
    end else begin
      rdData = {5'b0, cmd.eolFlag, (count == '0), cmd.rdValid,
                (cmd.rdValid ? headPix : {PIX_W{1'b0}})};
    end
  end

  // R4: never remove more pixels than the queue holds
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(popTotal) <= count);
  // R11: fill level stays within the queue depth
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R9: streaming and register reads never drain in the same cycle
  a_r9_modes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strmPop |-> (cmd.popCnt == 2'd0));
endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl import prr_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [31:0]      ctrlWdata,
  input  logic             dataRe,
  input  logic             dataWe,
  input  logic [1:0]       reqBits,
  input  logic [CNT_W-1:0] fillCount,
  output logic             vstartReq,
  output logic             hstartReq,
  output dpCmd_t           cmd
);
  logic             enQ, clrQ, oneShotQ, packQ, regOutQ;
  logic [DIM_W-1:0] widthQ, heightQ;
  logic [DIM_W-1:0] colQ, lineQ, colNext, step;
  logic             eolQ, frameOn;
  logic             regOn, vsWr, hsWr, haveData, rdValid, pop;
  logic             lineEnd, lastLine;

  assign regOn    = enQ && regOutQ && !clrQ;
  assign vsWr     = dataWe && regOn && reqBits[1];
  assign hsWr     = dataWe && regOn && reqBits[0] && !reqBits[1];
  assign step     = packQ ? DIM_W'(2) : DIM_W'(1);
  assign haveData = fillCount >= (packQ ? CNT_W'(2) : CNT_W'(1));
  assign rdValid  = regOn && frameOn && !eolQ && haveData;
  assign pop      = dataRe && rdValid;
  assign colNext  = colQ + step;
  assign lineEnd  = colNext >= widthQ;
  assign lastLine = lineQ == (heightQ - DIM_W'(1));

  assign cmd.flush    = clrQ;
  assign cmd.popCnt   = pop ? (packQ ? 2'd2 : 2'd1) : 2'd0;
  assign cmd.packSel  = packQ;
  assign cmd.rdValid  = rdValid;
  assign cmd.eolFlag  = eolQ;
  assign cmd.streamOn = enQ && !regOutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0; clrQ <= 1'b0; oneShotQ <= 1'b0; packQ <= 1'b0; regOutQ <= 1'b0;
      widthQ <= '0; heightQ <= '0;
    end else if (ctrlWe) begin
      enQ      <= ctrlWdata[C_EN];
      clrQ     <= ctrlWdata[C_CLR];
      oneShotQ <= ctrlWdata[C_ONESHOT];
      packQ    <= ctrlWdata[C_PACK];
      regOutQ  <= ctrlWdata[C_REGOUT];
      widthQ   <= ctrlWdata[2*DIM_W-1:DIM_W];
      heightQ  <= ctrlWdata[DIM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ <= '0; lineQ <= '0; eolQ <= 1'b0; frameOn <= 1'b0;
      vstartReq <= 1'b0; hstartReq <= 1'b0;
    end else begin
      vstartReq <= vsWr;
      hstartReq <= hsWr;
      if (clrQ) begin
        colQ <= '0; lineQ <= '0; eolQ <= 1'b0; frameOn <= 1'b0;
      end else if (vsWr) begin
        colQ <= '0; lineQ <= '0; eolQ <= 1'b0; frameOn <= 1'b1;
      end else if (hsWr) begin
        if (frameOn) eolQ <= 1'b0;
      end else if (pop) begin
        if (lineEnd) begin
          colQ  <= '0;
          eolQ  <= 1'b1;
          lineQ <= lastLine ? '0 : lineQ + DIM_W'(1);
          if (lastLine && oneShotQ) frameOn <= 1'b0;
        end else begin
          colQ <= colNext;
        end
      end
    end
  end

  // R5: end-of-line holds until a start request or clear
  a_r5_eol_holds: assert property (@(posedge clk) disable iff (!rstN)
    (eolQ && !hsWr && !vsWr && !clrQ) |=> eolQ);
  // R6: a frame start lands at the origin with delivery running
  a_r6_frame_origin: assert property (@(posedge clk) disable iff (!rstN)
    vsWr |=> (frameOn && colQ == '0 && lineQ == '0 && !eolQ));
  // R2: clear leaves position and delivery reset
  a_r2_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    clrQ |=> (!frameOn && colQ == '0 && lineQ == '0 && !eolQ));
  // R8: a stopped frame only restarts on a frame start
  a_r8_no_self_restart: assert property (@(posedge clk) disable iff (!rstN)
    (!frameOn && !vsWr) |=> !frameOn);
endmodule

// File: rtl/pix_reg_readout.sv
module pix_reg_readout import prr_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inPixValid,
  input  logic [23:0]       inPixData,
  output logic              inPixReady,
  output logic              strmValid,
  output logic [23:0]       strmData,
  input  logic              strmReady,
  input  logic              ctrlWe,
  input  logic [31:0]       ctrlWdata,
  input  logic              dataRe,
  output logic [31:0]       dataRdata,
  input  logic              dataWe,
  input  logic [31:0]       dataWdata,
  output logic              vstartReq,
  output logic              hstartReq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCmd_t           cmd;
  logic [CNT_W-1:0] fillCount;
  logic             unusedBits;

  assign unusedBits = ^{dataWdata[29:0]};

  prr_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .dataRe(dataRe), .dataWe(dataWe),
    .reqBits({dataWdata[W_FRAME], dataWdata[W_LINE]}),
    .fillCount(fillCount),
    .vstartReq(vstartReq), .hstartReq(hstartReq),
    .cmd(cmd)
  );

  prr_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .inPixValid(inPixValid), .inPixData(inPixData), .inPixReady(inPixReady),
    .strmValid(strmValid), .strmData(strmData), .strmReady(strmReady),
    .rdData(dataRdata), .fillCount(fillCount)
  );
endmodule

// File: tb/pix_reg_readout_tb_top.sv
`timescale 1ns/1ps
module pix_reg_readout_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inPixValid = 1'b0;
  logic [23:0] inPixData = '0;
  logic        inPixReady;
  logic        strmValid;
  logic [23:0] strmData;
  logic        strmReady = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [31:0] ctrlWdata = '0;
  logic        dataRe = 1'b0;
  logic [31:0] dataRdata;
  logic        dataWe = 1'b0;
  logic [31:0] dataWdata = '0;
  logic        vstartReq, hstartReq;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  logic [23:0] expQ [$];

  localparam logic [31:0] EN = 32'h8000_0000, CLR = 32'h4000_0000, ONE = 32'h2000_0000,
                          PACK = 32'h0800_0000, REGO = 32'h0400_0000;

  always #2 clk = ~clk;

  pix_reg_readout dut_i (.*);

  function automatic logic [31:0] frameSize(input int w, input int h);
    return (32'(w) << 12) | 32'(h);
  endfunction

  function automatic logic [15:0] to16(input logic [23:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushPix(input logic [23:0] d);
    bit acc;
    @(negedge clk);
    inPixValid = 1'b1; inPixData = d;
    #1 acc = inPixReady;
    chk(acc, "R11 pixel accepted", {31'b0, acc}, 32'h1);
    @(posedge clk);
    if (acc) expQ.push_back(d);
    #1 inPixValid = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [31:0] v);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWdata = v;
    @(posedge clk);
    #1 ctrlWe = 1'b0;
  endtask

  // bit31 frame start, bit30 line start; checks the request pulse (R10)
  task automatic dataWrite(input logic [31:0] v);
    @(negedge clk);
    dataWe = 1'b1; dataWdata = v;
    @(posedge clk);
    #1 dataWe = 1'b0;
    chk(vstartReq == v[31], "R10 frame request pulse", {31'b0, vstartReq}, {31'b0, v[31]});
    chk(hstartReq == (v[30] && !v[31]), "R10 line request pulse", {31'b0, hstartReq},
        {31'b0, v[30] && !v[31]});
    @(posedge clk);
    #1 chk(!vstartReq && !hstartReq, "R10 pulse one cycle", {30'b0, vstartReq, hstartReq}, 32'h0);
  endtask

  // unpacked read: expValid pops the oldest expected pixel
  task automatic rdCheck(input bit expValid, input bit expEol, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    #1;
    if (expValid) exp = {8'h01, expQ[0]};
    else exp = {5'b0, expEol, (expQ.size() == 0), 1'b0, 24'h0};
    dataRe = 1'b1;
    chk(dataRdata == exp, tag, dataRdata, exp);
    @(posedge clk);
    if (expValid) void'(expQ.pop_front());
    #1 dataRe = 1'b0;
  endtask

  task automatic rdPacked(input bit expValid, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    #1;
    exp = expValid ? {to16(expQ[1]), to16(expQ[0])} : 32'h0;
    dataRe = 1'b1;
    chk(dataRdata == exp, tag, dataRdata, exp);
    @(posedge clk);
    if (expValid) begin void'(expQ.pop_front()); void'(expQ.pop_front()); end
    #1 dataRe = 1'b0;
  endtask

  // scoreboard monitor for the streaming port
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (monOn && strmValid && strmReady) begin
        if (expQ.size() == 0) chk(1'b0, "R9 unexpected stream pixel", {8'h0, strmData}, 32'h0);
        else begin
          chk(strmData == expQ[0], "R9 stream order", {8'h0, strmData}, {8'h0, expQ[0]});
          void'(expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(dataRdata == 32'h0200_0000, "R1 reset read value", dataRdata, 32'h0200_0000);
    chk(inPixReady && !strmValid && !vstartReq && !hstartReq, "R1 reset outputs",
        {28'b0, inPixReady, strmValid, vstartReq, hstartReq}, 32'h8);

    // continuous unpacked frame, 4 wide, 2 lines
    ctrlWrite(EN | REGO | frameSize(4, 2));
    pushPix(24'h112233); pushPix(24'h445566); pushPix(24'h778899);
    rdCheck(1'b0, 1'b0, "R6 read before frame start");
    dataWrite(32'h8000_0000);
    rdCheck(1'b1, 1'b0, "R3 pixel col0");
    rdCheck(1'b1, 1'b0, "R3 pixel col1");
    rdCheck(1'b1, 1'b0, "R3 pixel col2");
    rdCheck(1'b0, 1'b0, "R4 empty read no pop");
    pushPix(24'hA1B2C3); pushPix(24'hD4E5F6);
    rdCheck(1'b1, 1'b0, "R5 last column read");
    rdCheck(1'b0, 1'b1, "R5 end-of-line blocks");
    rdCheck(1'b0, 1'b1, "R4 blocked read keeps pixel");
    dataWrite(32'h4000_0000);
    rdCheck(1'b1, 1'b0, "R5 line start resumes");
    pushPix(24'h010203); pushPix(24'h040506); pushPix(24'h070809);
    rdCheck(1'b1, 1'b0, "R3 line1 col1");
    rdCheck(1'b1, 1'b0, "R3 line1 col2");
    rdCheck(1'b1, 1'b0, "R3 line1 col3");
    rdCheck(1'b0, 1'b1, "R5 eol with empty queue");
    pushPix(24'hCAFE01);
    dataWrite(32'h4000_0000);
    rdCheck(1'b1, 1'b0, "R8 continuous wrap to line0");

    // clear flushes queued pixels
    pushPix(24'h0F0F0F); pushPix(24'hF0F0F0);
    ctrlWrite(EN | REGO | CLR | frameSize(4, 2));
    @(negedge clk);
    #1 chk(!inPixReady, "R2 ready low while clear", {31'b0, inPixReady}, 32'h0);
    expQ.delete();
    @(negedge clk);
    #1 chk(dataRdata == 32'h0200_0000, "R2 queue flushed", dataRdata, 32'h0200_0000);

    // one-shot frame, 2 wide, 1 line
    ctrlWrite(EN | REGO | ONE | frameSize(2, 1));
    pushPix(24'h123456); pushPix(24'h654321); pushPix(24'h0A0B0C);
    dataWrite(32'h8000_0000);
    rdCheck(1'b1, 1'b0, "R8 one-shot col0");
    rdCheck(1'b1, 1'b0, "R8 one-shot col1");
    dataWrite(32'h4000_0000);
    rdCheck(1'b0, 1'b1, "R8 one-shot stopped after line start");
    dataWrite(32'h8000_0000);
    rdCheck(1'b1, 1'b0, "R8 new frame start resumes");

    // packed frame, 4 wide, 1 line
    ctrlWrite(EN | REGO | PACK | frameSize(4, 1));
    pushPix(24'hFF8040);
    dataWrite(32'h8000_0000);
    rdPacked(1'b0, "R7 one pixel is not enough");
    pushPix(24'h20C0E0);
    rdPacked(1'b1, "R7 packed pair cols 0-1");
    pushPix(24'h0000FF); pushPix(24'hFFFFFF);
    rdPacked(1'b1, "R7 packed pair cols 2-3");
    rdPacked(1'b0, "R7 end-of-line hides flags");
    pushPix(24'h13579B); pushPix(24'h2468AC);
    dataWrite(32'h4000_0000);
    rdPacked(1'b1, "R7 packed after line start");

    // streaming mode
    ctrlWrite(EN | frameSize(4, 1));
    pushPix(24'h5A5A5A); pushPix(24'hA5A5A5);
    @(negedge clk);
    #1 chk(strmValid && strmData == expQ[0], "R9 stream head while stalled",
           {7'b0, strmValid, strmData}, {8'h01, expQ[0]});
    rdCheck(1'b0, 1'b0, "R9 register read inert in stream mode");
    @(negedge clk);
    monOn = 1'b1;
    strmReady = 1'b1;
    pushPix(24'h300000); pushPix(24'h000030);
    repeat (6) @(negedge clk);
    #3 chk(expQ.size() == 0 && !strmValid, "R11 all pixels delivered once",
           {31'b0, strmValid} | 32'(expQ.size()), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule